// File: doc/BRIEF.md
# Hardwired Instruction-Step Sequencer

This block is the control core of a small 16-bit accumulator machine whose memory holds 4096 words of 16 bits. A 4-bit step counter is decoded into sixteen timing strobes. The top four bits of the instruction word are latched: the indirect flag and the 3-bit operation code, which is held as a one-hot set of eight lines. An interrupt-cycle flag is also kept here. From these, the block drives one strobe per cycle that names the register-transfer step the datapath must perform. The steps cover fetch, decode, indirect address read, the seven memory-reference operations and the interrupt entry sequence. It also drives a counter-clear signal.

The datapath registers, the memory and the arithmetic unit sit outside the block. The datapath reacts to the strobes. It feeds back the upper instruction bits, the interrupt enable, the two device-ready flags, a data-register-is-zero flag and a halt request from its register-operation decoding. When the interrupt flag is set, the first three steps carry out interrupt entry instead of a fetch.

Top module: `hw_step_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the step counter at step 0, clears the interrupt flag, the halt state and the indirect flag, and sets `op_dec_o` to 1 (operation 0). In the first cycle after reset, `uop_o` shows the fetch-address strobe (bit 0).
- R2: Exactly one bit of `t_strobe_o` is high in every cycle. Bit k is step k. The step advances by one each clock. When `sc_clr_o` is high, the next cycle is step 0.
- R3: With the interrupt flag low, step 0 raises the fetch-address strobe (bit 0), step 1 the fetch-word strobe (bit 1) and step 2 the decode strobe (bit 2). At decode, `ir_ctl[2:0]` (instruction bits 14..12) is latched so that `op_dec_o` bit n is high for operation n, and `ir_ctl[3]` (instruction bit 15) is latched into `ind_o`.
- R4: At step 3, operation 7 with the indirect flag low raises the register-operation strobe (bit 4). Operation 7 with the flag high raises the device-operation strobe (bit 5). Both also raise `sc_clr_o`. Operations 0..6 with the flag high raise the indirect-read strobe (bit 3). With the flag low, no strobe is raised.
- R5: Operations 0, 1 and 2 raise the data-read strobe (bit 6) at step 4. At step 5 they raise bit 7, 8 or 9 respectively, together with `sc_clr_o`.
- R6: Operation 3 raises the store strobe (bit 10) at step 4, and operation 4 raises the jump strobe (bit 11) at step 4. Both also raise `sc_clr_o` there.
- R7: Operation 5 raises the save-return strobe (bit 12) at step 4, then the call-jump strobe (bit 13) with `sc_clr_o` at step 5.
- R8: Operation 6 raises bit 6 at step 4 and the increment strobe (bit 14) at step 5. At step 6 it raises the write-back strobe (bit 15) with `sc_clr_o`, and `skip_o` follows `dr_zero_i` in that cycle only.
- R9: The interrupt flag is set on the clock after a cycle in which `ien_i` is high, one of `in_ready_i` or `out_ready_i` is high, and the step is not 0, 1 or 2. Request conditions seen only during steps 0..2 have no effect.
- R10: With the interrupt flag high, steps 0, 1 and 2 raise bits 16, 17 and 18 in place of the fetch strobes. Step 2 also raises `sc_clr_o`, and the interrupt flag is low from the next cycle.
- R11: A high `halt_i` during the register-operation strobe leaves the counter at step 0 with no strobes and `sc_clr_o` low until reset. At any other time `halt_i` has no effect.
- R12: At most one bit of `uop_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_ctl | input | 4 | Instruction bits 15..12: indirect flag, then operation code |
| ien_i | input | 1 | Interrupt enable from the datapath |
| in_ready_i | input | 1 | Input device has a character |
| out_ready_i | input | 1 | Output device can accept a character |
| dr_zero_i | input | 1 | Data register equals zero |
| halt_i | input | 1 | Halt request from register-operation decoding |
| t_strobe_o | output | 16 | One-hot timing strobes, bit k = step k |
| op_dec_o | output | 8 | Latched operation code, one-hot |
| ind_o | output | 1 | Latched indirect flag |
| int_cyc_o | output | 1 | Interrupt-cycle flag |
| uop_o | output | 19 | One-hot step strobes, bit encoding as in R3..R10 |
| sc_clr_o | output | 1 | Step counter returns to step 0 on next clock |
| skip_o | output | 1 | Increment program counter on a zero result |

## Verification
A corrupt step counter appears at once on `t_strobe_o`: a second strobe, a skipped step, or a missed return to step 0 one cycle after `sc_clr_o`. A wrong latched operation or indirect flag shows up at step 3 or 4. There the strobe drawn from the per-operation step table differs, or the instruction ends on the wrong step. A stuck or late interrupt flag is visible on the first step 0 after the request, where the interrupt strobes should replace the fetch strobes. A missed clear is visible one instruction later, when fetch should return.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SC_W = 4;
  localparam int OP_W = 3;

  // Step strobe positions on uop_o
  typedef enum int unsigned {
    U_FETCH_AR  = 0,
    U_FETCH_IR  = 1,
    U_DECODE    = 2,
    U_INDIRECT  = 3,
    U_REG_EXEC  = 4,
    U_IO_EXEC   = 5,
    U_RD_DR     = 6,
    U_AND_AC    = 7,
    U_ADD_AC    = 8,
    U_LDA_AC    = 9,
    U_STA_WR    = 10,
    U_BUN_JMP   = 11,
    U_BSA_SAVE  = 12,
    U_BSA_JMP   = 13,
    U_ISZ_INC   = 14,
    U_ISZ_WB    = 15,
    U_INT_SAVE  = 16,
    U_INT_STORE = 17,
    U_INT_VEC   = 18,
    U_COUNT     = 19
  } uop_e;

  localparam int N_U = int'(U_COUNT);
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int SC_W = 4,
  localparam int N_T = 1 << SC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           hold,
  output logic [N_T-1:0] t_oh
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk) begin
    if (rst)        sc_q <= '0;
    else if (clr)   sc_q <= '0;
    else if (!hold) sc_q <= sc_q + 1'b1;
  end

  generate
    for (genvar k = 0; k < N_T; k++) begin : g_tdec
      assign t_oh[k] = (sc_q == SC_W'(k));
    end
  endgenerate
endmodule

// File: rtl/seq_opdec.sv
module seq_opdec #(
  parameter int OP_W = 3,
  localparam int N_D = 1 << OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [OP_W-1:0] op_in,
  input  logic            i_in,
  output logic [N_D-1:0]  d_oh,
  output logic            i_q
);
  logic [OP_W-1:0] op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= '0;
      i_q  <= 1'b0;
    end else if (load) begin
      op_q <= op_in;
      i_q  <= i_in;
    end
  end

  generate
    for (genvar n = 0; n < N_D; n++) begin : g_ddec
      assign d_oh[n] = (op_q == OP_W'(n));
    end
  endgenerate
endmodule

// File: rtl/seq_uop.sv
module seq_uop
  import seq_pkg::*;
#(
  parameter int N_T = 16,
  parameter int N_D = 8
) (
  input  logic [N_T-1:0] t,
  input  logic [N_D-1:0] d,
  input  logic           i_q,
  input  logic           r_q,
  input  logic           halted_q,
  output logic [N_U-1:0] u,
  output logic           clr
);
  always_comb begin
    u = '0;
    if (!halted_q) begin
      u[U_FETCH_AR]  = !r_q && t[0];
      u[U_FETCH_IR]  = !r_q && t[1];
      u[U_DECODE]    = !r_q && t[2];
      u[U_INT_SAVE]  =  r_q && t[0];
      u[U_INT_STORE] =  r_q && t[1];
      u[U_INT_VEC]   =  r_q && t[2];
      u[U_INDIRECT]  = !d[7] &&  i_q && t[3];
      u[U_REG_EXEC]  =  d[7] && !i_q && t[3];
      u[U_IO_EXEC]   =  d[7] &&  i_q && t[3];
      u[U_RD_DR]     = t[4] && (d[0] || d[1] || d[2] || d[6]);
      u[U_AND_AC]    = d[0] && t[5];
      u[U_ADD_AC]    = d[1] && t[5];
      u[U_LDA_AC]    = d[2] && t[5];
      u[U_STA_WR]    = d[3] && t[4];
      u[U_BUN_JMP]   = d[4] && t[4];
      u[U_BSA_SAVE]  = d[5] && t[4];
      u[U_BSA_JMP]   = d[5] && t[5];
      u[U_ISZ_INC]   = d[6] && t[5];
      u[U_ISZ_WB]    = d[6] && t[6];
    end
  end

  assign clr = u[U_REG_EXEC] | u[U_IO_EXEC] | u[U_AND_AC] | u[U_ADD_AC]
             | u[U_LDA_AC] | u[U_STA_WR] | u[U_BUN_JMP] | u[U_BSA_JMP]
             | u[U_ISZ_WB] | u[U_INT_VEC];
endmodule

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl
  import seq_pkg::*;
#(
  parameter int SC_BITS = seq_pkg::SC_W,
  parameter int OP_BITS = seq_pkg::OP_W,
  localparam int N_T = 1 << SC_BITS,
  localparam int N_D = 1 << OP_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_BITS:0] ir_ctl,
  input  logic             ien_i,
  input  logic             in_ready_i,
  input  logic             out_ready_i,
  input  logic             dr_zero_i,
  input  logic             halt_i,
  output logic [N_T-1:0]   t_strobe_o,
  output logic [N_D-1:0]   op_dec_o,
  output logic             ind_o,
  output logic             int_cyc_o,
  output logic [N_U-1:0]   uop_o,
  output logic             sc_clr_o,
  output logic             skip_o
);
  logic r_q;
  logic halted_q;
  logic r_set;

  seq_timer #(.SC_W(SC_BITS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (sc_clr_o),
    .hold (halted_q),
    .t_oh (t_strobe_o)
  );

  seq_opdec #(.OP_W(OP_BITS)) u_opdec (
    .clk   (clk),
    .rst   (rst),
    .load  (uop_o[U_DECODE]),
    .op_in (ir_ctl[OP_BITS-1:0]),
    .i_in  (ir_ctl[OP_BITS]),
    .d_oh  (op_dec_o),
    .i_q   (ind_o)
  );

  seq_uop #(.N_T(N_T), .N_D(N_D)) u_uop (
    .t        (t_strobe_o),
    .d        (op_dec_o),
    .i_q      (ind_o),
    .r_q      (r_q),
    .halted_q (halted_q),
    .u        (uop_o),
    .clr      (sc_clr_o)
  );

  // Interrupt request is only taken outside the first three steps
  assign r_set = ien_i && (in_ready_i || out_ready_i)
              && !(t_strobe_o[0] || t_strobe_o[1] || t_strobe_o[2]);

  always_ff @(posedge clk) begin
    if (rst)                  r_q <= 1'b0;
    else if (uop_o[U_INT_VEC]) r_q <= 1'b0;
    else if (r_set)           r_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                   halted_q <= 1'b0;
    else if (uop_o[U_REG_EXEC] && halt_i)      halted_q <= 1'b1;
  end

  assign int_cyc_o = r_q;
  assign skip_o    = uop_o[U_ISZ_WB] && dr_zero_i;
endmodule

// File: rtl/seq_ctl_chk.sv
module seq_ctl_chk
  import seq_pkg::*;
#(
  parameter int SC_BITS = seq_pkg::SC_W,
  parameter int OP_BITS = seq_pkg::OP_W,
  localparam int N_T = 1 << SC_BITS,
  localparam int N_D = 1 << OP_BITS
) (
  input logic             clk,
  input logic             rst,
  input logic [OP_BITS:0] ir_ctl,
  input logic             ien_i,
  input logic             in_ready_i,
  input logic             out_ready_i,
  input logic             dr_zero_i,
  input logic             halt_i,
  input logic [N_T-1:0]   t_strobe_o,
  input logic [N_D-1:0]   op_dec_o,
  input logic             ind_o,
  input logic             int_cyc_o,
  input logic [N_U-1:0]   uop_o,
  input logic             sc_clr_o,
  input logic             skip_o
);
  a_r2_one_timing: assert property (@(posedge clk) disable iff (rst)
    $countones(t_strobe_o) == 1);

  a_r2_clear_to_t0: assert property (@(posedge clk) disable iff (rst)
    sc_clr_o |=> t_strobe_o[0]);

  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (!sc_clr_o && !t_strobe_o[0] && !t_strobe_o[N_T-1])
      |=> (t_strobe_o == ($past(t_strobe_o) << 1)));

  a_r12_uop_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(uop_o));

  a_r3_latch: assert property (@(posedge clk) disable iff (rst)
    uop_o[U_DECODE] |=> (op_dec_o[$past(ir_ctl[OP_BITS-1:0])]
                         && ind_o == $past(ir_ctl[OP_BITS])));

  a_r9_irq_set: assert property (@(posedge clk) disable iff (rst)
    (ien_i && (in_ready_i || out_ready_i)
     && !t_strobe_o[0] && !t_strobe_o[1] && !t_strobe_o[2]) |=> int_cyc_o);

  a_r10_irq_clear: assert property (@(posedge clk) disable iff (rst)
    uop_o[U_INT_VEC] |=> !int_cyc_o);

  a_r11_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (uop_o[U_REG_EXEC] && halt_i) |=> (t_strobe_o[0] && uop_o == '0));

  a_r8_skip: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> (t_strobe_o[6] && dr_zero_i && op_dec_o[6]));
endmodule

bind hw_step_ctrl seq_ctl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ir_ctl      (ir_ctl),
  .ien_i       (ien_i),
  .in_ready_i  (in_ready_i),
  .out_ready_i (out_ready_i),
  .dr_zero_i   (dr_zero_i),
  .halt_i      (halt_i),
  .t_strobe_o  (t_strobe_o),
  .op_dec_o    (op_dec_o),
  .ind_o       (ind_o),
  .int_cyc_o   (int_cyc_o),
  .uop_o       (uop_o),
  .sc_clr_o    (sc_clr_o),
  .skip_o      (skip_o)
);

// File: tb/hw_step_ctrl_bench.sv
`timescale 1ns/1ps
module hw_step_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ir_ctl = '0;
  logic        ien_i = 1'b0, in_ready_i = 1'b0, out_ready_i = 1'b0;
  logic        dr_zero_i = 1'b0, halt_i = 1'b0;
  logic [15:0] t_strobe_o;
  logic [7:0]  op_dec_o;
  logic        ind_o, int_cyc_o, sc_clr_o, skip_o;
  logic [18:0] uop_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hw_step_ctrl u_hw_step_ctrl (
    .clk(clk), .rst(rst), .ir_ctl(ir_ctl), .ien_i(ien_i),
    .in_ready_i(in_ready_i), .out_ready_i(out_ready_i),
    .dr_zero_i(dr_zero_i), .halt_i(halt_i), .t_strobe_o(t_strobe_o),
    .op_dec_o(op_dec_o), .ind_o(ind_o), .int_cyc_o(int_cyc_o),
    .uop_o(uop_o), .sc_clr_o(sc_clr_o), .skip_o(skip_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Expected strobe index per step, -1 for none (R3..R8)
  function automatic int exp_u(input int op, input bit ib, input int t);
    case (t)
      0: return 0;
      1: return 1;
      2: return 2;
      3: if (op == 7) return ib ? 5 : 4; else return ib ? 3 : -1;
      4: case (op) 0, 1, 2, 6: return 6; 3: return 10; 4: return 11;
                   5: return 12; default: return -1; endcase
      5: case (op) 0: return 7; 1: return 8; 2: return 9; 5: return 13;
                   6: return 14; default: return -1; endcase
      6: return (op == 6) ? 15 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_last(input int op);
    if (op == 7) return 3;
    if (op == 3 || op == 4) return 4;
    if (op == 6) return 6;
    return 5;
  endfunction

  function automatic string tag_of(input int op, input int t);
    if (t < 3) return "R3";
    if (t == 3) return "R4";
    if (op <= 2) return "R5";
    if (op <= 4) return "R6";
    if (op == 5) return "R7";
    return "R8";
  endfunction

  // Runs one instruction starting at a step-0 negedge with fetch active
  task automatic run_instr(input int op, input bit ib, input bit drz);
    logic [18:0] eu;
    int last;
    ir_ctl    = {ib, 3'(op)};
    dr_zero_i = drz;
    last = exp_last(op);
    for (int t = 0; t <= last; t++) begin
      eu = (exp_u(op, ib, t) < 0) ? 19'd0 : (19'd1 << exp_u(op, ib, t));
      chk(t_strobe_o == (16'd1 << t), "R2", 32'(t_strobe_o), 32'(16'd1 << t));
      chk(uop_o == eu, tag_of(op, t), 32'(uop_o), 32'(eu));
      chk(sc_clr_o == (t == last), "R2", 32'(sc_clr_o), 32'(t == last));
      chk(skip_o == (op == 6 && t == 6 && drz), "R8", 32'(skip_o),
          32'(op == 6 && t == 6 && drz));
      if (t == 3) begin
        chk(op_dec_o == (8'd1 << op), "R3", 32'(op_dec_o), 32'(8'd1 << op));
        chk(ind_o == ib, "R3", 32'(ind_o), 32'(ib));
      end
      step();
    end
    chk(t_strobe_o == 16'd1, "R2", 32'(t_strobe_o), 32'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    chk(t_strobe_o == 16'd1, "R1", 32'(t_strobe_o), 32'd1);
    chk(uop_o == 19'd1, "R1", 32'(uop_o), 32'd1);
    chk(int_cyc_o == 1'b0, "R1", 32'(int_cyc_o), 32'd0);
    chk(op_dec_o == 8'd1 && ind_o == 1'b0, "R1", 32'({ind_o, op_dec_o}), 32'd1);
    chk(sc_clr_o == 1'b0, "R1", 32'(sc_clr_o), 32'd0);
  endtask

  task automatic t_memops();
    for (int op = 0; op < 6; op++) begin
      run_instr(op, 1'b0, 1'b0);
      run_instr(op, 1'b1, 1'b0);
    end
  endtask

  task automatic t_regio();
    run_instr(7, 1'b0, 1'b0);
    run_instr(7, 1'b1, 1'b0);
  endtask

  task automatic t_isz();
    run_instr(6, 1'b0, 1'b1);
    run_instr(6, 1'b1, 1'b0);
  endtask

  task automatic t_irq();
    // R9 negative: flags without enable, enable without flags
    in_ready_i = 1'b1;
    run_instr(1, 1'b0, 1'b0);
    chk(int_cyc_o == 1'b0, "R9", 32'(int_cyc_o), 32'd0);
    in_ready_i = 1'b0; ien_i = 1'b1;
    run_instr(2, 1'b0, 1'b0);
    chk(int_cyc_o == 1'b0, "R9", 32'(int_cyc_o), 32'd0);
    // R9: request visible only during steps 0..2 is ignored
    ir_ctl = {1'b0, 3'd7};
    out_ready_i = 1'b1;
    repeat (3) step();
    out_ready_i = 1'b0;
    step();
    chk(int_cyc_o == 1'b0, "R9", 32'(int_cyc_o), 32'd0);
    chk(uop_o == 19'd1, "R9", 32'(uop_o), 32'd1);
    // R9/R10: request during a store instruction
    in_ready_i = 1'b1;
    run_instr(3, 1'b0, 1'b0);
    in_ready_i = 1'b0;
    chk(int_cyc_o == 1'b1, "R9", 32'(int_cyc_o), 32'd1);
    chk(uop_o == (19'd1 << 16), "R10", 32'(uop_o), 32'(19'd1 << 16));
    step();
    chk(uop_o == (19'd1 << 17), "R10", 32'(uop_o), 32'(19'd1 << 17));
    step();
    chk(uop_o == (19'd1 << 18) && sc_clr_o, "R10", 32'({sc_clr_o, uop_o}),
        32'({1'b1, 19'd1 << 18}));
    ien_i = 1'b0;
    step();
    chk(int_cyc_o == 1'b0, "R10", 32'(int_cyc_o), 32'd0);
    chk(uop_o == 19'd1 && t_strobe_o == 16'd1, "R10", 32'(uop_o), 32'd1);
  endtask

  task automatic t_halt();
    // R11: halt ignored outside the register-operation step
    halt_i = 1'b1;
    run_instr(2, 1'b0, 1'b0);
    run_instr(7, 1'b1, 1'b0);
    chk(uop_o == 19'd1, "R11", 32'(uop_o), 32'd1);
    // R11: halt taken at the register-operation step
    ir_ctl = {1'b0, 3'd7};
    repeat (3) step();
    chk(uop_o == (19'd1 << 4), "R11", 32'(uop_o), 32'(19'd1 << 4));
    step();
    halt_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(t_strobe_o == 16'd1, "R11", 32'(t_strobe_o), 32'd1);
      chk(uop_o == 19'd0 && !sc_clr_o, "R11", 32'({sc_clr_o, uop_o}), 32'd0);
      step();
    end
    t_reset();
    run_instr(4, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=hung exp=complete");
      finish_run();
    end
  end

  initial begin
    step();
    t_reset();
    t_memops();
    t_regio();
    t_isz();
    t_irq();
    t_halt();
    done = 1'b1;
    finish_run();
  end
endmodule